// File: doc/BRIEF.md
# Inter-Thread FIFO Communication Cell

This block is a single storage cell through which hardware threads hand data to each other. It holds a small circular FIFO of 64-bit words, an empty tag, a full tag and a register with one bit per thread that records which threads are waiting on the cell. A FIFO-mode enable, driven from outside, decides whether the cell acts on accesses at all.

Each access names a thread, a view and a direction, and carries write data for writes. The synchronous view refuses a read from an empty cell, or a write to a full one, and raises a stall response. It also notes the thread as waiting. The try view never refuses: a read from an empty cell returns zero, and a write to a full cell is discarded. Any access that goes ahead sends a one-cycle wake pulse to every waiting thread and clears the waiting set. A stalled thread retries after its wake pulse arrives.

The cell accepts one access per clock, and every response is registered one cycle after its request. The view is picked by a 2-bit code. Unused codes complete with zero data and raise an error pulse.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the empty tag is 1, the full tag is 0, the FIFO holds no entries, the waiting set is clear, and rsp_valid, rsp_stall, view_err and wake are all 0.
- R2: With fifo_mode low, any read through a valid view returns zero and any write is discarded. The tags, the contents, the waiting set and the wake outputs do not change.
- R3: Words leave the FIFO in the order they were written, including when the pointers wrap around the DEPTH entries. A read from a cell with no entries returns zero.
- R4: A read that leaves zero entries sets the empty tag. A write that brings the count to DEPTH sets the full tag.
- R5: Every read in FIFO mode clears the full tag, and every write in FIFO mode clears the empty tag.
- R6: A synchronous-view read (view code 2'b01) while the empty tag is set returns zero with rsp_stall high, adds the thread's bit to the waiting set, and removes no entry.
- R7: A synchronous-view write while the full tag is set raises rsp_stall, adds the thread's bit to the waiting set, and stores nothing.
- R8: An access in FIFO mode that is not refused drives wake with the waiting set for exactly one cycle, then clears the set. A refused access never drives wake.
- R9: A try-view access (view code 2'b10) never stalls. A try read from an empty cell returns zero, and a try write to a full cell is discarded.
- R10: View codes 2'b00 and 2'b11 complete with zero data and view_err high for one cycle. They cause no stall, no wake and no change of state.
- R11: Every request receives exactly one response, with rsp_valid high in the cycle after the request. A cycle with no request produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | FIFO-mode enable for the cell |
| req_valid | input | 1 | Access request this cycle |
| req_tid | input | TID_W | Requesting thread index |
| req_view | input | 2 | View code: 01 synchronous, 10 try, others invalid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Read data, zero when nothing was removed |
| rsp_stall | output | 1 | Access refused; the thread must wait and retry |
| view_err | output | 1 | Invalid view code was used |
| wake | output | THREADS | One-cycle wake pulse per waiting thread |
| empty_tag | output | 1 | Empty tag |
| full_tag | output | 1 | Full tag |

## Verification
Directed sequences park several threads on an empty cell and then on a full cell. This shows whether wake carries the whole waiting set or only one thread, and whether the set is cleared afterwards. The same sequences compare try and synchronous accesses at the empty and full boundaries, with FIFO mode off, and with invalid view codes, so that refusal, dropping and ignoring can each be told apart. A long pseudo-random mix of threads, views, directions and mode then runs the pointers around the small FIFO many times against an arithmetic model. That run separates correct wrap-around ordering from off-by-one errors in the pointers or the count.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [1:0] {
    VIEW_NONE = 2'b00,
    VIEW_SYNC = 2'b01,
    VIEW_TRY  = 2'b10,
    VIEW_RSVD = 2'b11
  } itc_view_e;
endpackage

// File: rtl/itc_view_decode.sv
module itc_view_decode
  import itc_pkg::*;
(
  input  logic [1:0] view,
  output logic       is_sync,
  output logic       is_try,
  output logic       is_bad
);
  always_comb begin
    is_sync = 1'b0;
    is_try  = 1'b0;
    is_bad  = 1'b0;
    case (itc_view_e'(view))
      VIEW_SYNC: is_sync = 1'b1;
      VIEW_TRY:  is_try  = 1'b1;
      default:   is_bad  = 1'b1;
    endcase
  end
endmodule

// File: rtl/itc_cell_ram.sv
module itc_cell_ram #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/itc_wait_mask.sv
module itc_wait_mask #(
  parameter int THREADS = 64,
  localparam int TID_W = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [TID_W-1:0]   set_tid,
  input  logic               clr_en,
  output logic [THREADS-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)         mask <= '0;
    else if (set_en) mask <= mask | (THREADS'(1) << set_tid);
    else if (clr_en) mask <= '0;
  end
endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell #(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 64,
  parameter int THREADS = 64,
  localparam int TID_W  = $clog2(THREADS),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_mode,
  input  logic               req_valid,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [1:0]         req_view,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_stall,
  output logic               view_err,
  output logic [THREADS-1:0] wake,
  output logic               empty_tag,
  output logic               full_tag
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic is_sync, is_try, is_bad;
  logic acc_ok, do_rd, do_wr, blocked, go, pop, push;
  logic [PTR_W-1:0] out_ptr, in_idx;
  logic [CNT_W-1:0] count, count_nxt;
  logic [THREADS-1:0] mask;
  logic [DATA_W-1:0] ram_q;
  logic pop_q;

  itc_view_decode u_dec (
    .view(req_view), .is_sync(is_sync), .is_try(is_try), .is_bad(is_bad)
  );

  always_comb begin
    acc_ok  = req_valid && (is_sync || is_try) && fifo_mode;
    do_rd   = acc_ok && !req_write;
    do_wr   = acc_ok && req_write;
    blocked = is_sync && ((do_rd && empty_tag) || (do_wr && full_tag));
    go      = (do_rd || do_wr) && !blocked;
    pop     = go && do_rd && (count != '0);
    push    = go && do_wr && (count != FULL_CNT);
    in_idx  = out_ptr + count[PTR_W-1:0];
    count_nxt = count;
    if (pop)  count_nxt = count - 1'b1;
    if (push) count_nxt = count + 1'b1;
  end

  itc_cell_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(push), .waddr(in_idx), .wdata(req_wdata),
    .re(pop), .raddr(out_ptr), .rdata(ram_q)
  );

  itc_wait_mask #(.THREADS(THREADS)) u_mask (
    .clk(clk), .rst(rst), .set_en(blocked), .set_tid(req_tid),
    .clr_en(go), .mask(mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_ptr   <= '0;
      count     <= '0;
      empty_tag <= 1'b1;
      full_tag  <= 1'b0;
    end else begin
      count <= count_nxt;
      if (pop) out_ptr <= out_ptr + 1'b1;
      if (do_rd) begin
        full_tag <= 1'b0;
        if (go && count_nxt == '0) empty_tag <= 1'b1;
      end
      if (do_wr) begin
        empty_tag <= 1'b0;
        if (go && count_nxt == FULL_CNT) full_tag <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_stall <= 1'b0;
      view_err  <= 1'b0;
      wake      <= '0;
      pop_q     <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_stall <= blocked;
      view_err  <= req_valid && is_bad;
      wake      <= go ? mask : '0;
      pop_q     <= pop;
    end
  end

  assign rsp_rdata = pop_q ? ram_q : '0;
endmodule

// File: rtl/itc_fifo_cell_chk.sv
module itc_fifo_cell_chk #(
  parameter int DATA_W  = 64,
  parameter int THREADS = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               fifo_mode,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               rsp_stall,
  input logic               view_err,
  input logic [THREADS-1:0] wake,
  input logic               empty_tag,
  input logic               full_tag
);
  // R6
  stall_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_stall |-> (rsp_rdata == '0));

  // R4
  tags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(empty_tag && full_tag));

  // R8
  wake_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
    (wake != '0) |-> (rsp_valid && !rsp_stall && !view_err));

  // R10
  bad_view_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    view_err |-> (rsp_rdata == '0 && !rsp_stall && wake == '0));

  // R11
  no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R2
  mode_off_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |=> ($stable(empty_tag) && $stable(full_tag) && !rsp_stall));
endmodule

bind itc_fifo_cell itc_fifo_cell_chk #(.DATA_W(DATA_W), .THREADS(THREADS)) u_chk (
  .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
  .view_err(view_err), .wake(wake), .empty_tag(empty_tag), .full_tag(full_tag)
);

// File: tb/itc_fifo_cell_test.sv
module itc_fifo_cell_test;
  localparam int D  = 4;
  localparam int DW = 64;
  localparam int T  = 8;
  localparam int TW = $clog2(T);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_mode = 1'b0;
  logic req_valid = 1'b0;
  logic [TW-1:0] req_tid = '0;
  logic [1:0] req_view = 2'b00;
  logic req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_stall, view_err, empty_tag, full_tag;
  logic [DW-1:0] rsp_rdata;
  logic [T-1:0] wake;

  int checks = 0;
  int errors = 0;

  // model state
  logic [DW-1:0] m_mem [D];
  int m_cnt = 0, m_out = 0;
  logic [T-1:0] m_mask = '0;
  logic m_empty = 1'b1, m_full = 1'b0;

  always #10 clk = ~clk;

  itc_fifo_cell #(.DEPTH(D), .DATA_W(DW), .THREADS(T)) uut (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .req_valid(req_valid),
    .req_tid(req_tid), .req_view(req_view), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_stall(rsp_stall), .view_err(view_err), .wake(wake),
    .empty_tag(empty_tag), .full_tag(full_tag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input int tid, input logic [1:0] view, input bit wr,
                        input logic [DW-1:0] data, input string req);
    logic [DW-1:0] e_data = '0;
    logic [T-1:0] e_wake = '0;
    bit e_stall = 0, e_err = 0;
    if (view != 2'b01 && view != 2'b10) e_err = 1;
    else if (fifo_mode) begin
      if (!wr) begin
        m_full = 1'b0;
        if (view == 2'b01 && m_empty) begin
          m_mask[tid] = 1'b1; e_stall = 1;
        end else begin
          e_wake = m_mask; m_mask = '0;
          if (m_cnt > 0) begin
            e_data = m_mem[m_out]; m_out = (m_out + 1) % D; m_cnt--;
          end
          if (m_cnt == 0) m_empty = 1'b1;
        end
      end else begin
        m_empty = 1'b0;
        if (view == 2'b01 && m_full) begin
          m_mask[tid] = 1'b1; e_stall = 1;
        end else begin
          e_wake = m_mask; m_mask = '0;
          if (m_cnt < D) begin
            m_mem[(m_out + m_cnt) % D] = data; m_cnt++;
          end
          if (m_cnt == D) m_full = 1'b1;
        end
      end
    end
    req_valid = 1'b1; req_tid = TW'(tid); req_view = view;
    req_write = wr; req_wdata = data;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R11", "rsp_valid", DW'(rsp_valid), 1);
    check(rsp_rdata == e_data, req, "rdata", rsp_rdata, e_data);
    check(rsp_stall == e_stall, req, "stall", DW'(rsp_stall), DW'(e_stall));
    check(wake == e_wake, req, "wake", DW'(wake), DW'(e_wake));
    check(view_err == e_err, req, "view_err", DW'(view_err), DW'(e_err));
    check(empty_tag == m_empty, req, "empty_tag", DW'(empty_tag), DW'(m_empty));
    check(full_tag == m_full, req, "full_tag", DW'(full_tag), DW'(m_full));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(empty_tag == 1'b1, "R1", "empty_tag", DW'(empty_tag), 1);
    check(full_tag == 1'b0, "R1", "full_tag", DW'(full_tag), 0);
    check(rsp_valid == 1'b0 && rsp_stall == 1'b0 && view_err == 1'b0, "R1",
          "resp flags", DW'({rsp_valid, rsp_stall, view_err}), 0);
    check(wake == '0, "R1", "wake", DW'(wake), 0);

    // R2 mode off: ignored
    access(1, 2'b01, 1, 64'h1111, "R2");
    access(1, 2'b10, 1, 64'h2222, "R2");
    access(2, 2'b01, 0, 0, "R2");
    fifo_mode = 1'b1;

    // R6 threads wait on empty cell
    access(3, 2'b01, 0, 0, "R6");
    access(5, 2'b01, 0, 0, "R6");
    // R8 a try write wakes both (mask 0x28)
    access(0, 2'b10, 1, 64'hA0, "R8");
    check(m_mask == '0, "R8", "model mask", DW'(m_mask), 0);
    access(0, 2'b01, 1, 64'hA1, "R4");
    access(0, 2'b01, 1, 64'hA2, "R4");
    access(0, 2'b01, 1, 64'hA3, "R4");
    // R7 sync write on full
    access(2, 2'b01, 1, 64'hBAD, "R7");
    access(6, 2'b01, 1, 64'hBAD2, "R7");
    // R9 try write on full dropped, wakes 0x44
    access(1, 2'b10, 1, 64'hDEAD, "R9");
    // R5 read clears full; R3 order
    access(4, 2'b01, 0, 0, "R5");
    access(4, 2'b01, 0, 0, "R3");
    access(4, 2'b10, 0, 0, "R3");
    access(4, 2'b01, 0, 0, "R4");
    // R9 try read on empty
    access(7, 2'b10, 0, 0, "R9");
    // R10 bad views
    access(1, 2'b00, 1, 64'h55, "R10");
    access(1, 2'b11, 0, 0, "R10");
    access(1, 2'b01, 0, 0, "R10");
    access(2, 2'b10, 1, 64'h77, "R5");

    // R11 idle cycle produces no response
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "idle rsp_valid", DW'(rsp_valid), 0);

    // R3 pseudo-random sweep
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fifo_mode = (lfsr[7:4] != 4'h0);
      v = (lfsr[11:9] == 3'b000) ? {lfsr[3], lfsr[3]} : (lfsr[2] ? 2'b01 : 2'b10);
      access(int'(lfsr[14:12]) % T, v, lfsr[0] ^ lfsr[8], {48'h0, lfsr} + 64'(i), "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule